// File: doc/BRIEF.md
# Logic BIST Controller with Deterministic Top-Up

This block runs a built-in self-test on a small combinational circuit under test (CUT). It sits in front of the CUT's inputs as a multiplexer. Outside a test run, the functional inputs pass straight through. When a run is started, the block takes over the CUT inputs. It first applies a programmed number of pseudo-random patterns from a shift register with external feedback. It then applies a handful of deterministic patterns held in a small parameter ROM. These catch faults that random patterns rarely excite.

Each cycle of a run, the CUT's response word is folded into a signature register with internal (modular) feedback. This register divides the response stream by its characteristic polynomial and starts from an all-zero value. After the last pattern, a single compare cycle checks the remainder against a stored good-machine signature. The block then raises `done` together with a `pass` bit.

Aliasing is possible: a faulty CUT may leave the same remainder as a good one. A pass is therefore strong evidence of a good CUT, not proof. A fail, however, is definite. The generator is reloaded from its seed at every start, so repeated runs on the same CUT give the same signature.

Top module: `lbist_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, `busy`, `done` and `pass` are 0 and `sig` is all zeros.
- R2: Whenever `busy` is 0, `cut_drive` equals `func_in` in the same cycle.
- R3: A start accepted while not busy makes the next cycle busy. In that cycle `sig` is zero, `done` and `pass` are 0, and `cut_drive` equals `LFSR_SEED`.
- R4: In the random phase, `N_RAND` patterns are driven, one per cycle. The first is `LFSR_SEED`, and each later pattern p' is derived from the previous pattern p as {p[IW-2:0], ^(p & LFSR_TAPS)}.
- R5: Directly after the random phase, `M_ROM` patterns are driven, one per cycle, in the order j = 0, 1, …. Pattern j is `ROM_DATA[j*IW +: IW]`.
- R6: On every pattern cycle, the signature s is updated from the response r as {s[SW-2:0],1'b0} ^ (s[SW-1] ? MISR_POLY : 0) ^ r. Here r is zero-extended, so response bit k enters stage k.
- R7: After the last pattern there is one busy compare cycle with `done` at 0. In the cycle after that, `done` is 1, `busy` is 0, and `pass` is 1 exactly when `sig` equals `GOLDEN_SIG`. `pass` is never 1 while `done` is 0.
- R8: A start pulse during a run is ignored. The pattern sequence and the final result are unchanged.
- R9: While not busy and without a start, `sig`, `done` and `pass` hold their values even if `func_in` changes.
- R10: Two runs on the same CUT produce the same signature and the same result.
- R11: A CUT whose faulty signature differs from `GOLDEN_SIG` is reported with `pass` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a self-test run when not busy |
| func_in | input | IW | Functional inputs destined for the CUT |
| cut_resp | input | OW | Response word from the CUT |
| cut_drive | output | IW | Multiplexed CUT input: functional or test pattern |
| busy | output | 1 | A run is in progress (pattern phases and compare) |
| done | output | 1 | The last run has finished |
| pass | output | 1 | The last run's signature matched the golden value |
| sig | output | SW | Current signature register contents |

## Verification
The bench builds the block with 8 CUT inputs, 4 outputs and an 8-bit signature. It uses 20 random patterns and 4 ROM patterns, one of them all-ones, so that a stuck-at-0 on an all-inputs AND output can only be excited in the ROM phase. The golden signature is computed in the bench from its own CUT model, and this short run keeps every pattern and signature step checkable one by one. Faults are injected on CUT inputs and outputs to reach both pass and fail results. The bench also pulses start in the middle of a run.

// File: rtl/lbist_pkg.sv
`timescale 1ns/1ps
package lbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAND,
        ST_ROM,
        ST_CMP,
        ST_DONE
    } lbist_state_e;

endpackage

// File: rtl/lbist_prpg.sv
`timescale 1ns/1ps
// Next-state function of the external-feedback pattern generator.
module lbist_prpg #(
    parameter int unsigned  W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    logic fb;

    always_comb begin
        fb  = ^(cur & TAPS);
        nxt = {cur[W-2:0], fb};
    end
endmodule

// File: rtl/lbist_misr_step.sv
`timescale 1ns/1ps
// One division step of the modular signature register with parallel inputs.
module lbist_misr_step #(
    parameter int unsigned   SW   = 8,
    parameter int unsigned   OW   = 4,
    parameter logic [SW-1:0] POLY = 8'h1D
) (
    input  logic [SW-1:0] cur,
    input  logic [OW-1:0] resp,
    output logic [SW-1:0] nxt
);
    logic [SW-1:0] resp_ext;
    logic [SW-1:0] shifted;

    always_comb begin
        resp_ext = SW'(resp);
        shifted  = {cur[SW-2:0], 1'b0};
        nxt      = shifted ^ (cur[SW-1] ? POLY : '0) ^ resp_ext;
    end
endmodule

// File: rtl/lbist_rom.sv
`timescale 1ns/1ps
// Small parameter ROM of deterministic top-up patterns.
module lbist_rom #(
    parameter int unsigned         IW   = 8,
    parameter int unsigned         M    = 4,
    parameter int unsigned         AW   = 2,
    parameter logic [M*IW-1:0]     DATA = '0
) (
    input  logic [AW-1:0] idx,
    output logic [IW-1:0] pat
);
    logic [IW-1:0] entry [M];

    for (genvar j = 0; j < M; j++) begin : g_entry
        assign entry[j] = DATA[j*IW +: IW];
    end

    always_comb begin
        pat = '0;
        if (int'(idx) < int'(M)) begin
            pat = entry[idx];
        end
    end
endmodule

// File: rtl/lbist_ctrl.sv
`timescale 1ns/1ps
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int unsigned       IW         = 8,
    parameter int unsigned       OW         = 4,
    parameter int unsigned       SW         = 8,
    parameter int unsigned       N_RAND     = 20,
    parameter int unsigned       M_ROM      = 4,
    parameter logic [IW-1:0]     LFSR_TAPS  = 8'hB8,
    parameter logic [IW-1:0]     LFSR_SEED  = 8'h01,
    parameter logic [SW-1:0]     MISR_POLY  = 8'h1D,
    parameter logic [M_ROM*IW-1:0] ROM_DATA = 32'h5A_A5_00_FF,
    parameter logic [SW-1:0]     GOLDEN_SIG = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] func_in,
    input  logic [OW-1:0] cut_resp,
    output logic [IW-1:0] cut_drive,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic [SW-1:0] sig
);
    localparam int unsigned MAX_PH = (N_RAND > M_ROM) ? N_RAND : M_ROM;
    localparam int unsigned CNT_W  = $clog2(MAX_PH) + 1;
    localparam int unsigned ROM_AW = (M_ROM > 1) ? $clog2(M_ROM) : 1;
    localparam logic [CNT_W-1:0] RAND_LAST = CNT_W'(N_RAND - 1);
    localparam logic [CNT_W-1:0] ROM_LAST  = CNT_W'(M_ROM - 1);

    typedef struct packed {
        lbist_state_e  state;
        logic [IW-1:0] lfsr;
        logic [SW-1:0] sig;
        logic [CNT_W-1:0] cnt;
        logic          done;
        logic          pass;
    } lbist_regs_t;

    lbist_regs_t   cur_q, nxt_d;
    logic [IW-1:0] prpg_nxt;
    logic [SW-1:0] misr_nxt;
    logic [IW-1:0] rom_pat;
    logic [IW-1:0] drive_d;

    lbist_prpg #(.W(IW), .TAPS(LFSR_TAPS)) u_prpg (
        .cur (cur_q.lfsr),
        .nxt (prpg_nxt)
    );

    lbist_misr_step #(.SW(SW), .OW(OW), .POLY(MISR_POLY)) u_misr (
        .cur  (cur_q.sig),
        .resp (cut_resp),
        .nxt  (misr_nxt)
    );

    lbist_rom #(.IW(IW), .M(M_ROM), .AW(ROM_AW), .DATA(ROM_DATA)) u_rom (
        .idx (cur_q.cnt[ROM_AW-1:0]),
        .pat (rom_pat)
    );

    always_comb begin
        nxt_d   = cur_q;
        drive_d = func_in;
        unique case (cur_q.state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    nxt_d.state = ST_RAND;
                    nxt_d.lfsr  = LFSR_SEED;
                    nxt_d.sig   = '0;
                    nxt_d.cnt   = '0;
                    nxt_d.done  = 1'b0;
                    nxt_d.pass  = 1'b0;
                end
            end
            ST_RAND: begin
                drive_d    = cur_q.lfsr;
                nxt_d.sig  = misr_nxt;
                nxt_d.lfsr = prpg_nxt;
                if (cur_q.cnt == RAND_LAST) begin
                    nxt_d.state = ST_ROM;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                end
            end
            ST_ROM: begin
                drive_d   = rom_pat;
                nxt_d.sig = misr_nxt;
                if (cur_q.cnt == ROM_LAST) begin
                    nxt_d.state = ST_CMP;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                end
            end
            ST_CMP: begin
                nxt_d.done  = 1'b1;
                nxt_d.pass  = (cur_q.sig == GOLDEN_SIG);
                nxt_d.state = ST_DONE;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, lfsr: LFSR_SEED, sig: '0,
                       cnt: '0, done: 1'b0, pass: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cut_drive = drive_d;
    assign busy      = (cur_q.state == ST_RAND) || (cur_q.state == ST_ROM) ||
                       (cur_q.state == ST_CMP);
    assign done      = cur_q.done;
    assign pass      = cur_q.pass;
    assign sig       = cur_q.sig;
endmodule

// File: rtl/lbist_chk.sv
`timescale 1ns/1ps
module lbist_chk #(
    parameter int unsigned   IW        = 8,
    parameter int unsigned   SW        = 8,
    parameter logic [IW-1:0] LFSR_SEED = 8'h01
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [IW-1:0] func_in,
    input logic [IW-1:0] cut_drive,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic [SW-1:0] sig
);
    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cut_drive == func_in);

    // R3
    start_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && sig == '0 && cut_drive == LFSR_SEED && !done && !pass));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(sig) && $stable(done) && $stable(pass)));

    // R7
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R7
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
endmodule

bind lbist_ctrl lbist_chk #(.IW(IW), .SW(SW), .LFSR_SEED(LFSR_SEED)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .func_in   (func_in),
    .cut_drive (cut_drive),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .sig       (sig)
);

// File: tb/test_lbist_ctrl.sv
`timescale 1ns/1ps
module test_lbist_ctrl;
    localparam int unsigned IW = 8;
    localparam int unsigned OW = 4;
    localparam int unsigned SW = 8;
    localparam int unsigned NR = 20;
    localparam int unsigned MR = 4;
    localparam logic [IW-1:0] TAPS = 8'hB8;
    localparam logic [IW-1:0] SEED = 8'h01;
    localparam logic [SW-1:0] POLY = 8'h1D;
    localparam logic [MR*IW-1:0] ROMD = 32'h5A_A5_00_FF;

    function automatic logic [OW-1:0] cut_eval(input logic [IW-1:0] in, input logic fen,
                                               input logic [3:0] site, input logic val);
        logic [IW-1:0] x;
        logic [OW-1:0] o;
        x = in;
        if (fen && site < 4'd8) x[site[2:0]] = val;
        o = {&x, x[7] ^ (x[2] & x[5]), (x[4] & x[5]) | x[6], ^x[3:0]};
        if (fen && site >= 4'd8) o[site[1:0]] = val;
        return o;
    endfunction

    function automatic logic [IW-1:0] lfsr_step(input logic [IW-1:0] p);
        return {p[IW-2:0], ^(p & TAPS)};
    endfunction

    function automatic logic [SW-1:0] misr_step(input logic [SW-1:0] s, input logic [OW-1:0] r);
        return {s[SW-2:0], 1'b0} ^ (s[SW-1] ? POLY : 8'h00) ^ {4'b0000, r};
    endfunction

    function automatic logic [SW-1:0] sig_of(input logic fen, input logic [3:0] site,
                                             input logic val);
        logic [SW-1:0] s;
        logic [IW-1:0] p;
        s = '0;
        p = SEED;
        for (int k = 0; k < int'(NR); k++) begin
            s = misr_step(s, cut_eval(p, fen, site, val));
            p = lfsr_step(p);
        end
        for (int j = 0; j < int'(MR); j++) begin
            s = misr_step(s, cut_eval(ROMD[j*IW +: IW], fen, site, val));
        end
        return s;
    endfunction

    function automatic logic [IW-1:0] exp_pat(input int i);
        logic [IW-1:0] p;
        p = SEED;
        if (i >= int'(NR)) return ROMD[(i - int'(NR))*IW +: IW];
        for (int k = 0; k < i; k++) p = lfsr_step(p);
        return p;
    endfunction

    localparam logic [SW-1:0] GOLD = sig_of(1'b0, 4'd0, 1'b0);

    // Stimulus vectors: {fault_en, site, value, mid_run_start}
    localparam int NV = 6;
    localparam logic [6:0] VEC [NV] = '{
        {1'b0, 4'd0,  1'b0, 1'b0},
        {1'b1, 4'd11, 1'b0, 1'b0},
        {1'b1, 4'd0,  1'b1, 1'b1},
        {1'b1, 4'd9,  1'b0, 1'b0},
        {1'b1, 4'd7,  1'b0, 1'b0},
        {1'b0, 4'd0,  1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [IW-1:0] func_in = '0;
    logic [OW-1:0] cut_resp;
    logic [IW-1:0] cut_drive;
    logic          busy, done, pass;
    logic [SW-1:0] sig;
    logic          f_en = 1'b0;
    logic [3:0]    f_site = '0;
    logic          f_val = 1'b0;
    int            total = 0;
    int            bad = 0;
    logic [SW-1:0] first_sig;

    always #2.5 clk = ~clk;

    always_comb cut_resp = cut_eval(cut_drive, f_en, f_site, f_val);

    lbist_ctrl #(
        .IW(IW), .OW(OW), .SW(SW), .N_RAND(NR), .M_ROM(MR),
        .LFSR_TAPS(TAPS), .LFSR_SEED(SEED), .MISR_POLY(POLY),
        .ROM_DATA(ROMD), .GOLDEN_SIG(GOLD)
    ) i_lbist_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .func_in(func_in),
        .cut_resp(cut_resp), .cut_drive(cut_drive), .busy(busy),
        .done(done), .pass(pass), .sig(sig)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [6:0] v, output logic [SW-1:0] got);
        logic [SW-1:0] esig;
        int            mism;
        f_en   = v[6];
        f_site = v[5:2];
        f_val  = v[1];
        esig   = sig_of(v[6], v[5:2], v[1]);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && sig == '0 && !done && !pass, "R3 start state", {busy, done, pass, sig}, 11'h400);
        mism = 0;
        for (int i = 0; i < int'(NR + MR); i++) begin
            if (cut_drive != exp_pat(i)) begin
                mism++;
                $display("FAIL R4/R5 pattern %0d actual=%0h expected=%0h", i, cut_drive, exp_pat(i));
            end
            if (v[0] && i == 5) start = 1'b1;
            if (v[0] && i == 6) start = 1'b0;
            @(negedge clk);
        end
        total++;
        if (mism != 0) bad++;
        check(busy && !done, "R7 compare cycle", {busy, done}, 2'b10);
        @(negedge clk);
        check(done && !busy, "R7 done", {done, busy}, 2'b10);
        check(sig == esig, v[0] ? "R8 R6 signature" : "R6 signature", sig, esig);
        check(pass == (esig == GOLD), (esig == GOLD) ? "R7 pass" : "R11 fail reported",
              pass, (esig == GOLD));
        got = sig;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [SW-1:0] s;
        repeat (3) @(negedge clk);
        check(!busy && !done && !pass && sig == '0, "R1 reset state", {busy, done, pass, sig}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !pass && sig == '0, "R1 after release", {busy, done, pass, sig}, 0);
        for (int k = 0; k < 4; k++) begin
            func_in = 8'h3C ^ IW'(k * 37);
            #1;
            check(cut_drive == func_in, "R2 idle passthrough", cut_drive, func_in);
            @(negedge clk);
        end
        for (int n = 0; n < NV; n++) begin
            run_one(VEC[n], s);
            if (n == 0) first_sig = s;
        end
        check(s == first_sig, "R10 repeat run", s, first_sig);
        check(first_sig == GOLD, "R10 good signature", first_sig, GOLD);
        for (int k = 0; k < 3; k++) begin
            func_in = 8'hA0 + IW'(k);
            @(negedge clk);
            check(sig == first_sig && done && pass, "R9 hold when idle", sig, first_sig);
            check(cut_drive == func_in, "R2 passthrough after run", cut_drive, func_in);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule